// File: doc/BRIEF.md
# Software-Triggered Strobe Timer Channel

This block is one timer channel that emits a single active-low strobe, one count clock wide, a programmed number of count clocks after software writes a count value. The count clock is presented as a one-system-clock enable pulse, `cnt_fall`, that marks each falling edge of the count clock. All state changes on the system clock.

Software writes the count over an 8-bit bus. In single-byte mode one write is a complete count. In two-byte mode the low byte is written first and the high byte second. Only the second write commits the value. A committed count is moved into the down-counter on the next count-clock edge, and that edge does not decrement it, so a count of N gives a strobe N+1 count clocks after the write. Writing a new count while a count is running restarts the sequence. The `gate` input pauses and resumes counting and never drives the output directly.

Top module: `strobe_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `strobe_n` is forced high and the two-byte write phase returns to low-byte.
- R2: The first `cnt_fall` after a commit only loads the count into the counter and does not decrement it; `strobe_n` is high after that edge.
- R3: For a committed count N (1 to 65535) with `gate` high, `strobe_n` goes low after the (N+1)th `cnt_fall` following the commit. It returns high after the next `cnt_fall`.
- R4: When `gate` is low, a `cnt_fall` neither decrements the counter nor moves the strobe closer. `strobe_n` changes only in a cycle with `cnt_fall`, so `gate` never changes it directly.
- R5: A count committed while a count is running is loaded on the next `cnt_fall`. The strobe then comes N+1 `cnt_fall` edges after that commit, not at the old count's time.
- R6: With `two_byte`=1, writes alternate low byte then high byte, and the count is {high, low}. The low-byte write leaves the running count and its strobe time unchanged.
- R7: After reset and before the first commit, the channel stays idle and `strobe_n` stays high whatever `cnt_fall` and `gate` do.
- R8: After a strobe, no further strobe occurs until software commits a new count.
- R9: When a commit and a `cnt_fall` fall in the same system cycle, that edge acts on the old state, and the new count is loaded on the following `cnt_fall`.
- R10: With `two_byte`=0, one write commits {8'h00, data} and returns the byte phase to low-byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_fall | input | 1 | One-cycle pulse marking a count-clock falling edge |
| gate | input | 1 | High enables counting, low freezes it |
| wr_en | input | 1 | Count-write strobe, one cycle per byte |
| wr_data | input | 8 | Count byte being written |
| two_byte | input | 1 | 1: low byte then high byte; 0: single low byte |
| strobe_n | output | 1 | Active-low strobe output |

## Verification
The two functions that can meet in one cycle are a software commit and the count-clock edge that would fire the strobe for the old count. The bench raises `wr_en` and `cnt_fall` on the same system clock once the old count has reached one. The expected result is that the strobe still fires on that edge, the following edge only loads the new count with the output high, and the new strobe arrives N+1 edges after the commit. A retrigger partway through a count, and a low-byte write partway through a count, are judged the same way, by counting edges until the strobe appears.

// File: rtl/strobe_timer_pkg.sv
// Shared types for the strobe timer channel.
// Assumes: the count is exactly two bus bytes wide.
package strobe_timer_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } byte_phase_e;
endpackage

// File: rtl/strobe_byte_loader.sv
// Collects count bytes from the write bus and produces a one-cycle commit
// with the assembled count. Two-byte mode takes the low byte first and the
// high byte second. Single-byte mode zero-extends and resets the phase.
// Assumes: wr_en pulses are one system cycle per byte.
module strobe_byte_loader
    import strobe_timer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  two_byte,
    output logic                  commit,
    output logic [2*BYTE_W-1:0]   commit_val,
    output logic                  hi_phase
);
    localparam int CNT_W = 2 * BYTE_W;

    byte_phase_e       phase_q;
    logic [BYTE_W-1:0] low_q;

    // Commit on a single-byte write or on the high byte of a pair.
    always_comb begin
        commit     = wr_en && (!two_byte || (phase_q == PH_HIGH));
        commit_val = two_byte ? {wr_data, low_q} : CNT_W'(wr_data);
    end

    assign hi_phase = (phase_q == PH_HIGH);

    // Track the byte phase and hold the low byte until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
            low_q   <= '0;
        end else if (wr_en) begin
            if (!two_byte) begin
                phase_q <= PH_LOW;
            end else if (phase_q == PH_LOW) begin
                low_q   <= wr_data;
                phase_q <= PH_HIGH;
            end else begin
                phase_q <= PH_LOW;
            end
        end
    end
endmodule

// File: rtl/strobe_count_element.sv
// Down-counter of the channel. A commit is held pending and moved into the
// counter on the next count-clock edge without decrementing. Later edges
// decrement while the gate is high. Flags the edge that takes the count
// from one to zero. The counter wraps and keeps running after that.
// Assumes: cnt_fall is a one-cycle pulse; a commit in the same cycle as
// cnt_fall is seen only from the following edge on.
module strobe_count_element #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_fall,
    input  logic             gate,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    output logic             load_evt,
    output logic             zero_evt,
    output logic             load_pend,
    output logic             running
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ce_q;
    logic [CNT_W-1:0] pend_val_q;
    logic             dec_en;

    // Classify this cycle's count-clock edge as a load, a decrement or neither.
    always_comb begin
        load_evt = cnt_fall && load_pend;
        dec_en   = cnt_fall && !load_pend && running && gate;
        zero_evt = dec_en && (ce_q == ONE);
    end

    // Hold the committed value until the next count-clock edge takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pend  <= 1'b0;
            pend_val_q <= '0;
        end else if (commit) begin
            load_pend  <= 1'b1;
            pend_val_q <= commit_val;
        end else if (cnt_fall) begin
            load_pend  <= 1'b0;
        end
    end

    // Load or decrement the counter on count-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= '0;
            running <= 1'b0;
        end else if (load_evt) begin
            ce_q    <= pend_val_q;
            running <= 1'b1;
        end else if (dec_en) begin
            ce_q    <= ce_q - ONE;
        end
    end
endmodule

// File: rtl/strobe_shaper.sv
// Drives the active-low strobe. A load arms one strobe. The armed zero
// event pulls the output low for one count clock, and every other
// count-clock edge drives it high.
// Assumes: load_evt and zero_evt are never high together.
module strobe_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_fall,
    input  logic load_evt,
    input  logic zero_evt,
    output logic strobe_n
);
    logic live_q;

    // Arm on load; disarm once the strobe has fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else if (load_evt) begin
            live_q <= 1'b1;
        end else if (zero_evt) begin
            live_q <= 1'b0;
        end
    end

    // Update the output only on count-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_n <= 1'b1;
        end else if (cnt_fall) begin
            strobe_n <= !(zero_evt && live_q);
        end
    end
endmodule

// File: rtl/strobe_timer.sv
// Top of the software-triggered strobe timer channel: byte loader, count
// element and output shaper.
// Assumes: cnt_fall is a synchronous one-cycle enable in the clk domain.
module strobe_timer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_fall,
    input  logic              gate,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              two_byte,
    output logic              strobe_n
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             commit;
    logic [CNT_W-1:0] commit_val;
    logic             hi_phase;
    logic             load_evt;
    logic             zero_evt;
    logic             load_pend;
    logic             running;

    strobe_byte_loader #(.BYTE_W(BYTE_W)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .two_byte   (two_byte),
        .commit     (commit),
        .commit_val (commit_val),
        .hi_phase   (hi_phase)
    );

    strobe_count_element #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_fall   (cnt_fall),
        .gate       (gate),
        .commit     (commit),
        .commit_val (commit_val),
        .load_evt   (load_evt),
        .zero_evt   (zero_evt),
        .load_pend  (load_pend),
        .running    (running)
    );

    strobe_shaper u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_fall (cnt_fall),
        .load_evt (load_evt),
        .zero_evt (zero_evt),
        .strobe_n (strobe_n)
    );
endmodule

// File: rtl/strobe_timer_chk.sv
// Protocol checker for strobe_timer, attached by bind below.
// Assumes: reset is held for at least one clock at start-up.
module strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic cnt_fall,
    input logic wr_en,
    input logic two_byte,
    input logic strobe_n,
    input logic hi_phase,
    input logic load_pend,
    input logic running
);
    // R3: a low strobe lasts until the next count-clock edge only.
    p_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_fall && !strobe_n) |=> strobe_n);

    // R4: the output moves only on count-clock edges, never from the gate.
    p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_fall |=> $stable(strobe_n));

    // R2: the load edge never produces the strobe.
    p_load_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_fall && load_pend) |=> strobe_n);

    // R7: no strobe before the first count has been loaded.
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> strobe_n);

    // R6: a low-byte write does not request a load.
    p_first_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && two_byte && !hi_phase && !load_pend) |=> !load_pend);

    // R6: each two-byte write flips the byte phase.
    p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && two_byte) |=> (hi_phase != $past(hi_phase)));
endmodule

bind strobe_timer strobe_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_fall  (cnt_fall),
    .wr_en     (wr_en),
    .two_byte  (two_byte),
    .strobe_n  (strobe_n),
    .hi_phase  (hi_phase),
    .load_pend (load_pend),
    .running   (running)
);

// File: tb/sim_strobe_timer.sv
// Directed bench for strobe_timer: one task per scenario.
module sim_strobe_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_fall = 1'b0;
    logic       gate = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       two_byte = 1'b0;
    logic       strobe_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    strobe_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_fall (cnt_fall),
        .gate     (gate),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .two_byte (two_byte),
        .strobe_n (strobe_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) cnt_fall = 1'b1;
        @(negedge clk) cnt_fall = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input logic two);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; two_byte = two; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    // Count edges until strobe_n goes low; returns 0 if it never does.
    task automatic edges_to_low(input int max, output int k);
        k = 0;
        for (int i = 1; i <= max; i++) begin
            tick();
            if (!strobe_n) begin k = i; break; end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cnt_fall = 1'b0; wr_en = 1'b0; gate = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_idle();
        int lows = 0;
        do_reset();
        check(strobe_n == 1'b1, "R1", strobe_n, 1);
        for (int i = 0; i < 10; i++) begin
            gate = i[0];
            tick();
            if (!strobe_n) lows++;
        end
        gate = 1'b1;
        check(lows == 0, "R7", lows, 0);
    endtask

    task automatic t_basic();
        int k;
        int lows = 0;
        wr(8'd5, 1'b0);
        edges_to_low(20, k);
        check(k == 6, "R3", k, 6);
        tick();
        check(strobe_n == 1'b1, "R3 return high", strobe_n, 1);
        for (int i = 0; i < 30; i++) begin
            tick();
            if (!strobe_n) lows++;
        end
        check(lows == 0, "R8", lows, 0);
    endtask

    task automatic t_load_edge();
        int k;
        wr(8'd1, 1'b0);
        tick();
        check(strobe_n == 1'b1, "R2 load edge", strobe_n, 1);
        edges_to_low(5, k);
        check(k == 1, "R2 second edge", k, 1);
        tick();
    endtask

    task automatic t_gate();
        int lows = 0;
        wr(8'd4, 1'b0);
        tick(); tick();
        gate = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (!strobe_n) lows++;
        end
        check(lows == 0, "R4 frozen", lows, 0);
        gate = 1'b1;
        tick(); tick();
        check(strobe_n == 1'b1, "R4 resumed", strobe_n, 1);
        tick();
        check(strobe_n == 1'b0, "R4 late strobe", strobe_n, 0);
        gate = 1'b0;
        repeat (3) @(negedge clk);
        check(strobe_n == 1'b0, "R4 no direct gate effect", strobe_n, 0);
        tick();
        check(strobe_n == 1'b1, "R4 one clock", strobe_n, 1);
        gate = 1'b1;
    endtask

    task automatic t_two_byte();
        int k;
        wr(8'h03, 1'b1);
        wr(8'h01, 1'b1);
        edges_to_low(400, k);
        check(k == 260, "R6 16-bit count", k, 260);
        tick();
    endtask

    task automatic t_first_byte();
        int k;
        wr(8'd8, 1'b1);
        wr(8'd0, 1'b1);
        repeat (3) tick();
        wr(8'd2, 1'b1);
        edges_to_low(20, k);
        check(k == 6, "R6 low byte no effect", k, 6);
        tick();
        wr(8'd0, 1'b1);
        edges_to_low(20, k);
        check(k == 3, "R6 high byte commits", k, 3);
        tick();
    endtask

    task automatic t_retrigger();
        int k;
        wr(8'd6, 1'b0);
        repeat (4) tick();
        wr(8'd3, 1'b0);
        edges_to_low(20, k);
        check(k == 4, "R5", k, 4);
        tick();
    endtask

    task automatic t_same_cycle();
        int k;
        wr(8'd3, 1'b0);
        repeat (3) tick();
        check(strobe_n == 1'b1, "R9 before", strobe_n, 1);
        @(negedge clk) begin
            cnt_fall = 1'b1; wr_en = 1'b1; wr_data = 8'd2; two_byte = 1'b0;
        end
        @(negedge clk) begin cnt_fall = 1'b0; wr_en = 1'b0; end
        check(strobe_n == 1'b0, "R9 old strobe", strobe_n, 0);
        tick();
        check(strobe_n == 1'b1, "R9 load edge", strobe_n, 1);
        edges_to_low(10, k);
        check(k == 2, "R9 new count", k, 2);
        tick();
    endtask

    task automatic t_single_clears_phase();
        int k;
        wr(8'd9, 1'b1);
        wr(8'd5, 1'b0);
        edges_to_low(20, k);
        check(k == 6, "R10 single byte", k, 6);
        tick();
        wr(8'd2, 1'b1);
        wr(8'd0, 1'b1);
        edges_to_low(20, k);
        check(k == 3, "R10 phase reset", k, 3);
        tick();
    endtask

    initial begin
        t_reset_idle();
        t_basic();
        t_load_edge();
        t_gate();
        t_two_byte();
        t_first_byte();
        t_retrigger();
        t_same_cycle();
        t_single_clears_phase();
        wr(8'd7, 1'b0);
        do_reset();
        check(strobe_n == 1'b1, "R1 mid-run reset", strobe_n, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule